// File: doc/BRIEF.md
# Instruction Step Sequencer with Skip

This block is the control sequencer of a small 16-bit processor. It runs one instruction per request. On each `step_i` pulse it reads the word at the program counter from a single word-addressed memory, moves the counter on, and splits the word into a 4-bit operation code and two 6-bit operand selectors. It then asks an external operand resolver for each operand in turn and hands the values to an external ALU. When the operation code is zero, it runs one of its own extended operations instead.

The program counter and stack pointer live inside the sequencer. Operand resolution may push, pop or consume an extra instruction word, and the sequencer applies those side effects. A conditional operation can set a skip flag. The next instruction is then still fully resolved, so the counter passes its extra words, but it is discarded and the stack pointer returns to the value it held before that instruction was decoded. Every step ends with a one-cycle `done_o` pulse that carries the cycle cost of the step and the halted status.

Top module: `isq_step_seq`

## Requirements
- R1: After reset the sequencer is idle with PC = 0, SP = 0, halted_o = 0 and done_o = 0, and it drives no memory access.
- R2: A step reads memory at PC. PC then increases by one. Bits 3:0 of the word are the operation code, bits 9:4 are the a selector and bits 15:10 are the b selector.
- R3: For a nonzero operation code the a selector goes to the resolver before the b selector. The ALU receives the operation code and both resolved values. Each resolver answer adds its word consumption (`res_pc_inc_i`) to PC and applies its stack action: 1 = increment SP, 2 = decrement SP.
- R4: For operation code 0 only the b selector is resolved, the a selector is taken as the extended operation number, and the ALU is not started.
- R5: While the skip flag is set, the next instruction has its operands resolved, with their PC and SP effects, but it is not executed. SP returns to its value from before that instruction's decode, and the flag clears so that the instruction after it executes. The flag is set when the ALU reports a skip.
- R6: Extended operation 0 (no-op) adds 1 cycle and changes no state.
- R7: Extended operation 1 (subroutine call) decrements SP, writes the PC (already past the instruction) to memory at the new SP, loads PC with the b value, and adds 2 cycles.
- R8: Extended operation 2 (halt) sets halted_o and adds no cycles. Any later step performs no memory access, leaves PC unchanged and ends with done_o, halted_o = 1 and a cycle count of 0.
- R9: Extended operation numbers of 3 and above have no effect on PC, SP, memory or the halted state, and add no cycles.
- R10: cycles_o at done_o equals the sum of the resolver costs, the ALU cost and the extended-operation cost of that step. done_o is high for exactly one cycle.
- R11: When the ALU requests a write, wb_en_o pulses with the a selector and the result. A selector of 0x1B loads SP with the result, and a selector of 0x1C loads PC with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | Start one instruction step (taken while idle) |
| done_o | output | 1 | One-cycle pulse at the end of a step |
| halted_o | output | 1 | Processor has executed a halt |
| cycles_o | output | CW (8) | Cycle cost of the last step |
| pc_o | output | DW (16) | Program counter |
| sp_o | output | DW (16) | Stack pointer |
| mem_addr_o | output | DW (16) | Memory word address |
| mem_rd_o | output | 1 | Memory read strobe (data valid the next cycle) |
| mem_rdata_i | input | DW (16) | Memory read data |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | DW (16) | Memory write data |
| res_req_o | output | 1 | Operand resolution request |
| res_code_o | output | FW (6) | Operand selector to resolve |
| res_ack_i | input | 1 | Resolver answer valid |
| res_val_i | input | DW (16) | Resolved operand value |
| res_cost_i | input | 2 | Extra cycles charged by the resolution |
| res_pc_inc_i | input | 1 | Resolution consumed one instruction word |
| res_sp_op_i | input | 2 | Stack action: 0 none, 1 increment, 2 decrement |
| alu_go_o | output | 1 | ALU start |
| alu_op_o | output | OPW (4) | Operation code for the ALU |
| alu_a_o | output | DW (16) | Operand a value |
| alu_b_o | output | DW (16) | Operand b value |
| alu_done_i | input | 1 | ALU result valid |
| alu_res_i | input | DW (16) | ALU result |
| alu_wr_i | input | 1 | ALU result is to be written back |
| alu_skip_i | input | 1 | Condition failed: skip the next instruction |
| alu_cost_i | input | 2 | Cycles charged by the operation |
| wb_en_o | output | 1 | Write-back strobe |
| wb_code_o | output | FW (6) | Write-back target selector (the a selector) |
| wb_data_o | output | DW (16) | Write-back value |

## Verification
The hardest case to reach is a skipped instruction whose operands move the stack pointer and consume an extra word. SP must return to its value from before decode while PC keeps the advance. The bench reaches this case by running a failing equality test with two literals, followed by a move whose a selector is a push and whose b selector is an immediate word. It then checks that PC passes the immediate, that SP is back where it was, that neither the ALU nor write-back fired, and that the next instruction runs again. The call that writes the return address to the top of memory, and the steps after a halt, are checked through the bench's own memory model and the done-time outputs.

// File: rtl/isq_pkg.sv
package isq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_RES_A,
        ST_RES_B,
        ST_EXEC,
        ST_PUSH_RET,
        ST_DONE
    } isq_state_e;

    typedef enum logic [1:0] {
        EXT_NOP,
        EXT_CALL,
        EXT_HALT,
        EXT_NONE
    } isq_ext_e;

    // stack actions reported by the operand resolver
    localparam logic [1:0] SPOP_NONE = 2'd0;
    localparam logic [1:0] SPOP_INC  = 2'd1;
    localparam logic [1:0] SPOP_DEC  = 2'd2;

    // operand selectors that name the sequencer-owned pointers
    localparam logic [5:0] SEL_SP = 6'h1b;
    localparam logic [5:0] SEL_PC = 6'h1c;

endpackage

// File: rtl/isq_decode.sv
module isq_decode
    import isq_pkg::*;
#(
    parameter int IW    = 16,
    parameter int OPW   = 4,
    parameter int FW    = 6,
    parameter int N_EXT = 3
) (
    input  logic [IW-1:0]  instr_i,
    output logic [OPW-1:0] op_o,
    output logic [FW-1:0]  a_sel_o,
    output logic [FW-1:0]  b_sel_o,
    output logic           is_ext_o,
    output isq_ext_e       ext_kind_o
);
    localparam int A_LO = OPW;
    localparam int B_LO = OPW + FW;

    always_comb begin
        op_o     = instr_i[OPW-1:0];
        a_sel_o  = instr_i[A_LO +: FW];
        b_sel_o  = instr_i[B_LO +: FW];
        is_ext_o = (op_o == '0);
        if (a_sel_o >= FW'(N_EXT)) begin
            ext_kind_o = EXT_NONE;
        end else begin
            case (a_sel_o)
                FW'(0):  ext_kind_o = EXT_NOP;
                FW'(1):  ext_kind_o = EXT_CALL;
                FW'(2):  ext_kind_o = EXT_HALT;
                default: ext_kind_o = EXT_NONE;
            endcase
        end
    end

endmodule

// File: rtl/isq_sp_step.sv
module isq_sp_step
    import isq_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] sp_i,
    input  logic [1:0]    act_i,
    output logic [DW-1:0] sp_o
);
    always_comb begin
        case (act_i)
            SPOP_INC: sp_o = sp_i + DW'(1);
            SPOP_DEC: sp_o = sp_i - DW'(1);
            default:  sp_o = sp_i;
        endcase
    end

endmodule

// File: rtl/isq_cost_add.sv
module isq_cost_add #(
    parameter int CW = 8,
    parameter int AMW = 2
) (
    input  logic [CW-1:0]  acc_i,
    input  logic [AMW-1:0] amt_i,
    output logic [CW-1:0]  sum_o
);
    logic [CW:0] wide;

    always_comb begin
        wide  = {1'b0, acc_i} + (CW+1)'(amt_i);
        sum_o = wide[CW] ? {CW{1'b1}} : wide[CW-1:0];
    end

endmodule

// File: rtl/isq_step_seq.sv
module isq_step_seq
    import isq_pkg::*;
#(
    parameter int DW    = 16,
    parameter int OPW   = 4,
    parameter int FW    = 6,
    parameter int CW    = 8,
    parameter int N_EXT = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step_i,
    output logic           done_o,
    output logic           halted_o,
    output logic [CW-1:0]  cycles_o,
    output logic [DW-1:0]  pc_o,
    output logic [DW-1:0]  sp_o,
    output logic [DW-1:0]  mem_addr_o,
    output logic           mem_rd_o,
    input  logic [DW-1:0]  mem_rdata_i,
    output logic           mem_wr_o,
    output logic [DW-1:0]  mem_wdata_o,
    output logic           res_req_o,
    output logic [FW-1:0]  res_code_o,
    input  logic           res_ack_i,
    input  logic [DW-1:0]  res_val_i,
    input  logic [1:0]     res_cost_i,
    input  logic           res_pc_inc_i,
    input  logic [1:0]     res_sp_op_i,
    output logic           alu_go_o,
    output logic [OPW-1:0] alu_op_o,
    output logic [DW-1:0]  alu_a_o,
    output logic [DW-1:0]  alu_b_o,
    input  logic           alu_done_i,
    input  logic [DW-1:0]  alu_res_i,
    input  logic           alu_wr_i,
    input  logic           alu_skip_i,
    input  logic [1:0]     alu_cost_i,
    output logic           wb_en_o,
    output logic [FW-1:0]  wb_code_o,
    output logic [DW-1:0]  wb_data_o
);
    localparam int IW = OPW + 2 * FW;
    localparam int AMW = 2;

    typedef struct packed {
        isq_state_e    st;
        logic [DW-1:0] pc;
        logic [DW-1:0] sp;
        logic [DW-1:0] sp_save;
        logic [IW-1:0] instr;
        logic [DW-1:0] a_val;
        logic [DW-1:0] b_val;
        logic [CW-1:0] cyc;
        logic          skip;
        logic          halted;
    } seq_t;

    seq_t s_q, s_d;

    logic [OPW-1:0] dec_op;
    logic [FW-1:0]  dec_a, dec_b;
    logic           dec_ext;
    isq_ext_e       dec_kind;
    logic [DW-1:0]  sp_res;
    logic [AMW-1:0] cost_amt;
    logic [CW-1:0]  cyc_sum;

    isq_decode #(.IW(IW), .OPW(OPW), .FW(FW), .N_EXT(N_EXT)) i_decode (
        .instr_i    (s_q.instr),
        .op_o       (dec_op),
        .a_sel_o    (dec_a),
        .b_sel_o    (dec_b),
        .is_ext_o   (dec_ext),
        .ext_kind_o (dec_kind)
    );

    isq_sp_step #(.DW(DW)) i_sp_step (
        .sp_i  (s_q.sp),
        .act_i (res_sp_op_i),
        .sp_o  (sp_res)
    );

    isq_cost_add #(.CW(CW), .AMW(AMW)) i_cost_add (
        .acc_i (s_q.cyc),
        .amt_i (cost_amt),
        .sum_o (cyc_sum)
    );

    // cost charged in the current state
    always_comb begin
        cost_amt = '0;
        case (s_q.st)
            ST_RES_A, ST_RES_B: cost_amt = res_cost_i;
            ST_EXEC: begin
                if (dec_ext) begin
                    case (dec_kind)
                        EXT_NOP:  cost_amt = AMW'(1);
                        EXT_CALL: cost_amt = AMW'(2);
                        default:  cost_amt = '0;
                    endcase
                end else begin
                    cost_amt = alu_cost_i;
                end
            end
            default: cost_amt = '0;
        endcase
    end

    always_comb begin
        s_d         = s_q;
        done_o      = 1'b0;
        mem_addr_o  = s_q.pc;
        mem_rd_o    = 1'b0;
        mem_wr_o    = 1'b0;
        mem_wdata_o = s_q.pc;
        res_req_o   = 1'b0;
        res_code_o  = dec_a;
        alu_go_o    = 1'b0;
        alu_op_o    = dec_op;
        alu_a_o     = s_q.a_val;
        alu_b_o     = s_q.b_val;
        wb_en_o     = 1'b0;
        wb_code_o   = dec_a;
        wb_data_o   = alu_res_i;

        case (s_q.st)
            ST_IDLE: begin
                if (step_i) begin
                    s_d.cyc = '0;
                    s_d.st  = s_q.halted ? ST_DONE : ST_FETCH;
                end
            end
            ST_FETCH: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = s_q.pc;
                s_d.st     = ST_DECODE;
            end
            ST_DECODE: begin
                s_d.instr   = mem_rdata_i[IW-1:0];
                s_d.pc      = s_q.pc + DW'(1);
                s_d.sp_save = s_q.sp;
                s_d.st      = (mem_rdata_i[OPW-1:0] == '0) ? ST_RES_B : ST_RES_A;
            end
            ST_RES_A: begin
                res_req_o  = 1'b1;
                res_code_o = dec_a;
                if (res_ack_i) begin
                    s_d.a_val = res_val_i;
                    s_d.cyc   = cyc_sum;
                    s_d.pc    = s_q.pc + DW'(res_pc_inc_i);
                    s_d.sp    = sp_res;
                    s_d.st    = ST_RES_B;
                end
            end
            ST_RES_B: begin
                res_req_o  = 1'b1;
                res_code_o = dec_b;
                if (res_ack_i) begin
                    s_d.b_val = res_val_i;
                    s_d.cyc   = cyc_sum;
                    s_d.pc    = s_q.pc + DW'(res_pc_inc_i);
                    if (s_q.skip) begin
                        s_d.skip = 1'b0;
                        s_d.sp   = s_q.sp_save;
                        s_d.st   = ST_DONE;
                    end else begin
                        s_d.sp = sp_res;
                        s_d.st = ST_EXEC;
                    end
                end
            end
            ST_EXEC: begin
                if (dec_ext) begin
                    s_d.cyc = cyc_sum;
                    s_d.st  = ST_DONE;
                    case (dec_kind)
                        EXT_CALL: begin
                            s_d.sp = s_q.sp - DW'(1);
                            s_d.st = ST_PUSH_RET;
                        end
                        EXT_HALT: s_d.halted = 1'b1;
                        default: ;
                    endcase
                end else begin
                    alu_go_o = 1'b1;
                    if (alu_done_i) begin
                        s_d.cyc  = cyc_sum;
                        s_d.skip = alu_skip_i;
                        s_d.st   = ST_DONE;
                        if (alu_wr_i) begin
                            wb_en_o = 1'b1;
                            if (dec_a == SEL_SP) s_d.sp = alu_res_i;
                            if (dec_a == SEL_PC) s_d.pc = alu_res_i;
                        end
                    end
                end
            end
            ST_PUSH_RET: begin
                mem_wr_o    = 1'b1;
                mem_addr_o  = s_q.sp;
                mem_wdata_o = s_q.pc;
                s_d.pc      = s_q.b_val;
                s_d.st      = ST_DONE;
            end
            ST_DONE: begin
                done_o = 1'b1;
                s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign halted_o = s_q.halted;
    assign cycles_o = s_q.cyc;
    assign pc_o     = s_q.pc;
    assign sp_o     = s_q.sp;

endmodule

// File: rtl/isq_step_seq_chk.sv
module isq_step_seq_chk #(
    parameter int DW  = 16,
    parameter int OPW = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           done_o,
    input logic           halted_o,
    input logic           mem_rd_o,
    input logic           mem_wr_o,
    input logic [DW-1:0]  pc_o,
    input logic [DW-1:0]  sp_o,
    input logic           alu_go_o,
    input logic [OPW-1:0] alu_op_o
);
    // R10
    done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |=> halted_o);

    // R8
    halt_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |-> !mem_rd_o);

    // R2
    fetch_pc_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> ##1 (pc_o == $past(pc_o, 2) + DW'(1)));

    // R4
    ext_no_alu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alu_go_o |-> (alu_op_o != '0));

    // R7
    call_store_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |=> (done_o && $stable(sp_o)));

endmodule

bind isq_step_seq isq_step_seq_chk #(.DW(DW), .OPW(OPW)) i_isq_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .done_o   (done_o),
    .halted_o (halted_o),
    .mem_rd_o (mem_rd_o),
    .mem_wr_o (mem_wr_o),
    .pc_o     (pc_o),
    .sp_o     (sp_o),
    .alu_go_o (alu_go_o),
    .alu_op_o (alu_op_o)
);

// File: tb/test_isq_step_seq.sv
module test_isq_step_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0;
    logic        done_o, halted_o;
    logic [7:0]  cycles_o;
    logic [15:0] pc_o, sp_o, mem_addr_o, mem_rdata_i, mem_wdata_o;
    logic        mem_rd_o, mem_wr_o;
    logic        res_req_o, res_ack_i, res_pc_inc_i;
    logic [5:0]  res_code_o;
    logic [15:0] res_val_i;
    logic [1:0]  res_cost_i, res_sp_op_i;
    logic        alu_go_o, alu_done_i, alu_wr_i, alu_skip_i;
    logic [3:0]  alu_op_o;
    logic [15:0] alu_a_o, alu_b_o, alu_res_i;
    logic [1:0]  alu_cost_i;
    logic        wb_en_o;
    logic [5:0]  wb_code_o;
    logic [15:0] wb_data_o;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    isq_step_seq i_isq_step_seq (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .done_o(done_o),
        .halted_o(halted_o), .cycles_o(cycles_o), .pc_o(pc_o), .sp_o(sp_o),
        .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_rdata_i(mem_rdata_i),
        .mem_wr_o(mem_wr_o), .mem_wdata_o(mem_wdata_o),
        .res_req_o(res_req_o), .res_code_o(res_code_o), .res_ack_i(res_ack_i),
        .res_val_i(res_val_i), .res_cost_i(res_cost_i), .res_pc_inc_i(res_pc_inc_i),
        .res_sp_op_i(res_sp_op_i), .alu_go_o(alu_go_o), .alu_op_o(alu_op_o),
        .alu_a_o(alu_a_o), .alu_b_o(alu_b_o), .alu_done_i(alu_done_i),
        .alu_res_i(alu_res_i), .alu_wr_i(alu_wr_i), .alu_skip_i(alu_skip_i),
        .alu_cost_i(alu_cost_i), .wb_en_o(wb_en_o), .wb_code_o(wb_code_o),
        .wb_data_o(wb_data_o)
    );

    // memory model: 256 words, read data one cycle after the strobe
    logic [15:0] mem [0:255];
    logic        tb_we = 1'b0;
    logic [7:0]  tb_wa = '0;
    logic [15:0] tb_wd = '0;

    always @(posedge clk) begin
        if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o[7:0]];
        if (mem_wr_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;
        else if (tb_we) mem[tb_wa] <= tb_wd;
    end

    // operand resolver model, answers in the request cycle
    always_comb begin
        res_ack_i    = res_req_o;
        res_cost_i   = 2'd0;
        res_pc_inc_i = 1'b0;
        res_sp_op_i  = 2'd0;
        res_val_i    = 16'h0;
        if (res_code_o < 6'h08)       res_val_i = 16'h0100 + 16'(res_code_o);
        else if (res_code_o < 6'h18)  res_val_i = 16'h0200;
        else if (res_code_o == 6'h18) begin res_val_i = mem[sp_o[7:0]]; res_sp_op_i = 2'd1; end
        else if (res_code_o == 6'h19) res_val_i = mem[sp_o[7:0]];
        else if (res_code_o == 6'h1a) begin res_val_i = 16'h0; res_sp_op_i = 2'd2; end
        else if (res_code_o == 6'h1b) res_val_i = sp_o;
        else if (res_code_o == 6'h1c) res_val_i = pc_o;
        else if (res_code_o == 6'h1d) res_val_i = 16'h0;
        else if (res_code_o <= 6'h1f) begin
            res_val_i = mem[pc_o[7:0]]; res_pc_inc_i = 1'b1; res_cost_i = 2'd1;
        end
        else res_val_i = 16'(res_code_o - 6'h20);
    end

    // ALU model
    always_comb begin
        alu_done_i = alu_go_o;
        alu_wr_i   = (alu_op_o >= 4'd1) && (alu_op_o <= 4'd11);
        alu_skip_i = (alu_op_o == 4'd12) && (alu_a_o != alu_b_o);
        alu_cost_i = (alu_op_o == 4'd1) ? 2'd1 : 2'd2;
        case (alu_op_o)
            4'd1:    alu_res_i = alu_b_o;
            4'd2:    alu_res_i = alu_a_o + alu_b_o;
            default: alu_res_i = alu_a_o ^ alu_b_o;
        endcase
    end

    // event log per step
    logic log_clr = 1'b0;
    int n_res, n_alu, n_wb, n_rd, n_wr;
    logic [5:0]  code0, code1, wb_code_seen;
    logic [3:0]  op_seen;
    logic [15:0] a_seen, b_seen, wb_data_seen;

    always @(posedge clk) begin
        if (log_clr) begin
            n_res <= 0; n_alu <= 0; n_wb <= 0; n_rd <= 0; n_wr <= 0;
            code0 <= '0; code1 <= '0;
        end else begin
            if (res_req_o && res_ack_i) begin
                if (n_res == 0) code0 <= res_code_o;
                if (n_res == 1) code1 <= res_code_o;
                n_res <= n_res + 1;
            end
            if (alu_go_o && alu_done_i) begin
                n_alu <= n_alu + 1; op_seen <= alu_op_o;
                a_seen <= alu_a_o; b_seen <= alu_b_o;
            end
            if (wb_en_o) begin
                n_wb <= n_wb + 1; wb_code_seen <= wb_code_o; wb_data_seen <= wb_data_o;
            end
            if (mem_rd_o) n_rd <= n_rd + 1;
            if (mem_wr_o) n_wr <= n_wr + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_wa = a; tb_wd = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic do_step(input string tag);
        @(negedge clk); log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0; step_i = 1'b1;
        @(negedge clk); step_i = 1'b0;
        for (int i = 0; i < 40 && !done_o; i++) @(negedge clk);
        chk({tag, " done seen"}, 32'(done_o), 32'd1);
    endtask

    task automatic t_reset();
        chk("R1 pc", 32'(pc_o), 32'h0);
        chk("R1 sp", 32'(sp_o), 32'h0);
        chk("R1 halted", 32'(halted_o), 32'h0);
        chk("R1 done", 32'(done_o), 32'h0);
        chk("R1 mem strobes", {30'd0, mem_rd_o, mem_wr_o}, 32'h0);
    endtask

    task automatic t_basic_add();
        do_step("R2");
        chk("R2 one fetch", 32'(n_rd), 32'd1);
        chk("R3 first code a", 32'(code0), 32'h00);
        chk("R3 second code b", 32'(code1), 32'h1f);
        chk("R3 alu op", 32'(op_seen), 32'd2);
        chk("R3 alu a", 32'(a_seen), 32'h0100);
        chk("R3 alu b", 32'(b_seen), 32'h0005);
        chk("R3 pc past immediate", 32'(pc_o), 32'h2);
        chk("R10 cycles", 32'(cycles_o), 32'd3);
        chk("R11 wb count", 32'(n_wb), 32'd1);
        chk("R11 wb code", 32'(wb_code_seen), 32'h00);
        chk("R11 wb data", 32'(wb_data_seen), 32'h0105);
        @(negedge clk);
        chk("R10 done one cycle", 32'(done_o), 32'd0);
    endtask

    task automatic t_nop();
        do_step("R6");
        chk("R4 only b resolved", 32'(n_res), 32'd1);
        chk("R4 b code", 32'(code0), 32'h25);
        chk("R4 no alu", 32'(n_alu), 32'd0);
        chk("R6 cycles", 32'(cycles_o), 32'd1);
        chk("R6 pc", 32'(pc_o), 32'h3);
        chk("R6 sp", 32'(sp_o), 32'h0);
    endtask

    task automatic t_call();
        do_step("R7");
        chk("R7 sp", 32'(sp_o), 32'hFFFF);
        chk("R7 pc", 32'(pc_o), 32'h0040);
        chk("R7 write count", 32'(n_wr), 32'd1);
        chk("R7 return addr", 32'(mem[8'hFF]), 32'h0005);
        chk("R7 cycles", 32'(cycles_o), 32'd3);
    endtask

    task automatic t_skip();
        do_step("R5 test");
        chk("R5 test no wb", 32'(n_wb), 32'd0);
        chk("R10 test cycles", 32'(cycles_o), 32'd2);
        do_step("R5 skipped");
        chk("R5 skipped resolved", 32'(n_res), 32'd2);
        chk("R5 skipped no alu", 32'(n_alu), 32'd0);
        chk("R5 skipped no wb", 32'(n_wb), 32'd0);
        chk("R5 pc past word", 32'(pc_o), 32'h0043);
        chk("R5 sp restored", 32'(sp_o), 32'hFFFF);
        chk("R5 skipped cycles", 32'(cycles_o), 32'd1);
        do_step("R5 after");
        chk("R5 flag cleared alu", 32'(n_alu), 32'd1);
        chk("R5 after wb data", 32'(wb_data_seen), 32'h0101);
        chk("R5 after cycles", 32'(cycles_o), 32'd2);
    endtask

    task automatic t_ptr_wb();
        do_step("R11 sp");
        chk("R11 sp loaded", 32'(sp_o), 32'h001F);
        chk("R11 sp wb code", 32'(wb_code_seen), 32'h1b);
        chk("R11 sp cycles", 32'(cycles_o), 32'd1);
        do_step("R11 pc");
        chk("R11 pc loaded", 32'(pc_o), 32'h0080);
        chk("R11 pc cycles", 32'(cycles_o), 32'd2);
    endtask

    task automatic t_undef_ext();
        do_step("R9");
        chk("R9 pc", 32'(pc_o), 32'h0081);
        chk("R9 sp", 32'(sp_o), 32'h001F);
        chk("R9 no write", 32'(n_wr), 32'd0);
        chk("R9 no alu", 32'(n_alu), 32'd0);
        chk("R9 halted", 32'(halted_o), 32'd0);
        chk("R9 cycles", 32'(cycles_o), 32'd0);
    endtask

    task automatic t_halt();
        do_step("R8 halt");
        chk("R8 halted", 32'(halted_o), 32'd1);
        chk("R8 cycles", 32'(cycles_o), 32'd0);
        chk("R8 pc", 32'(pc_o), 32'h0082);
        do_step("R8 later");
        chk("R8 later halted", 32'(halted_o), 32'd1);
        chk("R8 later no fetch", 32'(n_rd), 32'd0);
        chk("R8 later no resolve", 32'(n_res), 32'd0);
        chk("R8 later cycles", 32'(cycles_o), 32'd0);
        chk("R8 later pc", 32'(pc_o), 32'h0082);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        load(8'h00, 16'h7C02); load(8'h01, 16'h0005);   // add reg0, imm
        load(8'h02, 16'h9400);                          // nop, literal 5
        load(8'h03, 16'h7C10); load(8'h04, 16'h0040);   // call imm
        load(8'h40, 16'h8A1C);                          // equality test 1 vs 2
        load(8'h41, 16'h7DA1); load(8'h42, 16'h1234);   // move push, imm (skipped)
        load(8'h43, 16'h8402);                          // add reg0, literal 1
        load(8'h44, 16'hFDB1);                          // move sp, literal 31
        load(8'h45, 16'h7DC1); load(8'h46, 16'h0080);   // move pc, imm
        load(8'h80, 16'h8050);                          // undefined extended 5
        load(8'h81, 16'h8020);                          // halt
        t_basic_add();
        t_nop();
        t_call();
        t_skip();
        t_ptr_wb();
        t_undef_ext();
        t_halt();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule